// File: doc/BRIEF.md
# Dithered Third-Order Noise Shaper

This block reduces a wide signed sample stream, already at the oversampled rate, to a small unsigned code. The code gives how many unit current elements of a multi-element DAC are switched on. The loop is third order and feed-forward. Its noise transfer function is exactly (1 − z⁻¹)³ and its signal transfer function is one. Quantization noise is therefore pushed to high frequencies, where later analog filtering removes it.

A pseudorandom term from a 35-bit maximal-length shift register can be added at the quantizer input. This term breaks up the periodic patterns the loop would otherwise settle into for constant or slowly moving inputs.

The block takes one sample per clock in which the valid strobe is high and returns one code in the next cycle. The integrators saturate instead of wrapping around. Any saturation event sets a sticky flag that only reset clears.

Top module: `noise_shaper3`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `code_o` = 16 (midscale), `code_vld_o` = 0 and `ovf_o` = 0; the three integrators are zero and the shift register holds `SEED`.
- R2: `code_vld_o` is 1 in the cycle after each cycle in which `din_vld_i` is 1, and 0 in the cycle after each cycle in which it is 0.
- R3: While `din_vld_i` is 0, `din_i` and `dith_en_i` are ignored: `code_o` holds its value, and no integrator or shift register state advances. The code sequence depends only on the accepted samples.
- R4: With step size 2^`STEP_W` and loop value v, the code is clamp(16 + floor((v + 2^(`STEP_W`−1)) / 2^`STEP_W`), 0, 32). The level fed back is (code − 16)·2^`STEP_W`.
- R5: For each accepted sample x (`din_i` as two's complement), the loop value is v = x + 3·s1 + 3·s2 + s3 + d. The updates are s1 ← s1 + (x − fb), s2 ← s2 + s1 and s3 ← s3 + s2, each using the old values. This gives an NTF of (1 − z⁻¹)³.
- R6: For a constant input within ±6 steps, the mean of (code − 16)·2^`STEP_W` over 256 samples from reset lies within one step of the input.
- R7: The dither d is the two's complement value of shift register bits [2:0] times 2^(`STEP_W`−3) when `dith_en_i` = 1, and zero when it is 0. The enable is taken with each accepted sample.
- R8: The shift register is 35 bits with polynomial x^35 + x^33 + 1. Its next state is {r[33:0], r[34] ^ r[32]}. It advances once per accepted sample, whatever the state of `dith_en_i`, and it is never all zero.
- R9: Each integrator is a signed `DATA_W`+`GUARD` bit value that clamps at its two's complement limits. A clamp in any accepted sample sets `ovf_o` from the next cycle on, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | DATA_W | Signed input sample |
| din_vld_i | input | 1 | Input sample strobe |
| dith_en_i | input | 1 | Adds dither when high |
| code_o | output | Q_BITS+1 | Element count, 0 to 32 |
| code_vld_o | output | 1 | Code strobe, one per accepted sample |
| ovf_o | output | 1 | Sticky integrator saturation flag |

## Verification
The bench builds the block with `DATA_W` = 32, `Q_BITS` = 5, `GUARD` = 4 and `STEP_W` = 26. With these values the input spans twice the quantizer's range, so a sustained full-scale input cannot be followed by the output. The error then piles up in the integrators, and the 36-bit integrators hit their limits within about eight samples. This puts the clamp, the sticky flag and both code limits within reach. The narrower step still leaves room for DC inputs of several steps, which the bit-exact reference and the averaging check cover with and without dither.

// File: rtl/ns3_pkg.sv
package ns3_pkg;

    // Dither source: 35-bit maximal-length shift register, x^35 + x^33 + 1
    localparam int LFSR_LEN    = 35;
    localparam int LFSR_TAP_HI = 34;
    localparam int LFSR_TAP_LO = 32;

    // Number of low register bits that form the signed dither value
    localparam int DITH_BITS   = 3;

    typedef logic [LFSR_LEN-1:0] lfsr_t;

    localparam lfsr_t LFSR_SEED_DEF = 35'h2_4C1F_9A37;

endpackage

// File: rtl/ns3_sat_add.sv
// Saturating accumulator step: sum = clamp(acc + inc) at W-bit two's complement limits.
module ns3_sat_add #(
    parameter int W = 40
) (
    input  logic signed [W-1:0] acc_i,
    input  logic signed [W-1:0] inc_i,
    output logic signed [W-1:0] sum_o,
    output logic                clip_o
);

    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide   = $signed({acc_i[W-1], acc_i}) + $signed({inc_i[W-1], inc_i});
        clip_o = wide[W] != wide[W-1];
        if (!clip_o) begin
            sum_o = wide[W-1:0];
        end else if (wide[W]) begin
            sum_o = MIN_V;
        end else begin
            sum_o = MAX_V;
        end
    end

endmodule

// File: rtl/ns3_lfsr_step.sv
// Next-state logic of the dither register and the signed dither value it presents.
module ns3_lfsr_step
    import ns3_pkg::*;
#(
    parameter lfsr_t SEED = LFSR_SEED_DEF
) (
    input  lfsr_t                        cur_i,
    output lfsr_t                        nxt_o,
    output logic signed [DITH_BITS-1:0]  dith_o
);

    lfsr_t shifted;

    always_comb begin
        shifted = {cur_i[LFSR_LEN-2:0], cur_i[LFSR_TAP_HI] ^ cur_i[LFSR_TAP_LO]};
        // the all-zero state is a lock-up: fall back to the seed
        if (shifted == '0) begin
            nxt_o = SEED;
        end else begin
            nxt_o = shifted;
        end
        dith_o = $signed(cur_i[DITH_BITS-1:0]);
    end

endmodule

// File: rtl/ns3_quant.sv
// Multi-level quantizer: round to the nearest step, offset to midscale, clamp to 0..2^Q_BITS.
module ns3_quant #(
    parameter int SUM_W  = 43,
    parameter int STEP_W = 27,
    parameter int Q_BITS = 5
) (
    input  logic signed [SUM_W-1:0] v_i,
    output logic [Q_BITS:0]         code_o
);

    localparam int CODE_W = Q_BITS + 1;
    localparam int MID    = 1 << (Q_BITS - 1);
    localparam int LEVELS = 1 << Q_BITS;

    localparam logic signed [SUM_W:0] HALF  = (SUM_W+1)'(1) <<< (STEP_W - 1);
    localparam logic signed [SUM_W:0] MID_S = (SUM_W+1)'(MID);

    logic signed [SUM_W:0] biased;
    logic signed [SUM_W:0] steps;

    always_comb begin
        biased = (SUM_W+1)'(v_i) + HALF;
        steps  = biased >>> STEP_W;
        if (steps >= MID_S) begin
            code_o = CODE_W'(LEVELS);
        end else if (steps <= -MID_S) begin
            code_o = '0;
        end else begin
            code_o = CODE_W'(steps + MID_S);
        end
    end

endmodule

// File: rtl/noise_shaper3.sv
// Third-order feed-forward noise shaper with optional pseudorandom dither.
// Delaying integrators with feed-forward weights 3, 3, 1 and a direct input path
// give NTF = (1 - z^-1)^3 and STF = 1.
module noise_shaper3
    import ns3_pkg::*;
#(
    parameter int    DATA_W = 32,
    parameter int    Q_BITS = 5,
    parameter int    STEP_W = DATA_W - Q_BITS,
    parameter int    GUARD  = 8,
    parameter lfsr_t SEED   = LFSR_SEED_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] din_i,
    input  logic              din_vld_i,
    input  logic              dith_en_i,
    output logic [Q_BITS:0]   code_o,
    output logic              code_vld_o,
    output logic              ovf_o
);

    localparam int CODE_W = Q_BITS + 1;
    localparam int LEVELS = 1 << Q_BITS;
    localparam int MID    = LEVELS / 2;
    localparam int ACC_W  = DATA_W + GUARD;
    localparam int SUM_W  = ACC_W + 3;
    localparam int N_INT  = 3;

    localparam logic signed [CODE_W:0] MID_S = (CODE_W+1)'(MID);

    typedef struct packed {
        logic [N_INT-1:0][ACC_W-1:0] integ;
        lfsr_t                       lfsr;
        logic [CODE_W-1:0]           code;
        logic                        vld;
        logic                        ovf;
    } state_t;

    localparam state_t RST_ST = '{
        integ: '0,
        lfsr:  SEED,
        code:  CODE_W'(MID),
        vld:   1'b0,
        ovf:   1'b0
    };

    state_t st_d, st_q;

    lfsr_t                       lfsr_nxt;
    lfsr_t                       lfsr_now;
    logic signed [DITH_BITS-1:0] dith_raw;
    logic signed [SUM_W-1:0]     d_term;
    logic signed [SUM_W-1:0]     v_sum;
    logic [CODE_W-1:0]           q_code;
    logic signed [CODE_W:0]      code_off;
    logic signed [ACC_W-1:0]     x_acc;
    logic signed [ACC_W-1:0]     fb_acc;
    logic signed [ACC_W-1:0]     err_acc;
    logic [N_INT-1:0][ACC_W-1:0] inc;
    logic [N_INT-1:0][ACC_W-1:0] nxt_int;
    logic [N_INT-1:0]            clip;

    function automatic logic signed [SUM_W-1:0] widen(input logic [ACC_W-1:0] a);
        return SUM_W'($signed(a));
    endfunction

    function automatic logic signed [SUM_W-1:0] times3(input logic [ACC_W-1:0] a);
        logic signed [SUM_W-1:0] w;
        w = SUM_W'($signed(a));
        return (w <<< 1) + w;
    endfunction

    // ---------------- sub-blocks ----------------
    ns3_lfsr_step #(
        .SEED (SEED)
    ) i_lfsr (
        .cur_i  (st_q.lfsr),
        .nxt_o  (lfsr_nxt),
        .dith_o (dith_raw)
    );

    ns3_quant #(
        .SUM_W  (SUM_W),
        .STEP_W (STEP_W),
        .Q_BITS (Q_BITS)
    ) i_quant (
        .v_i    (v_sum),
        .code_o (q_code)
    );

    for (genvar g = 0; g < N_INT; g++) begin : g_int
        ns3_sat_add #(
            .W (ACC_W)
        ) i_acc (
            .acc_i  (st_q.integ[g]),
            .inc_i  (inc[g]),
            .sum_o  (nxt_int[g]),
            .clip_o (clip[g])
        );
    end

    // ---------------- loop datapath ----------------
    always_comb begin
        x_acc  = ACC_W'($signed(din_i));
        d_term = '0;
        if (dith_en_i) begin
            d_term = SUM_W'(dith_raw) <<< (STEP_W - DITH_BITS);
        end
        v_sum = widen(x_acc)
              + times3(st_q.integ[0])
              + times3(st_q.integ[1])
              + widen(st_q.integ[2])
              + d_term;

        code_off = $signed({1'b0, q_code}) - MID_S;
        fb_acc   = ACC_W'(code_off) <<< STEP_W;
        err_acc  = x_acc - fb_acc;

        inc[0] = err_acc;
        for (int i = 1; i < N_INT; i++) begin
            inc[i] = st_q.integ[i-1];
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.vld = din_vld_i;
        if (din_vld_i) begin
            st_d.integ = nxt_int;
            st_d.lfsr  = lfsr_nxt;
            st_d.code  = q_code;
            st_d.ovf   = st_q.ovf | (|clip);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign lfsr_now   = st_q.lfsr;
    assign code_o     = st_q.code;
    assign code_vld_o = st_q.vld;
    assign ovf_o      = st_q.ovf;

endmodule

// File: rtl/ns3_chk.sv
module ns3_chk
    import ns3_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int MAXC   = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              din_vld_i,
    input logic [CODE_W-1:0] code_o,
    input logic              code_vld_o,
    input logic              ovf_o,
    input lfsr_t             lfsr_now
);

    // R2: one code strobe per accepted sample, none otherwise
    p_vld_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        din_vld_i |=> code_vld_o);
    p_no_spurious_vld_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !din_vld_i |=> !code_vld_o);

    // R3: idle cycles leave code and dither register untouched
    p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !din_vld_i |=> ($stable(code_o) && $stable(lfsr_now)));

    // R4: code never leaves 0..MAXC
    p_code_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_o <= CODE_W'(MAXC));

    // R8: register never all zero and moves on every accepted sample
    p_lfsr_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_now != '0);
    p_lfsr_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        din_vld_i |=> (lfsr_now != $past(lfsr_now)));

    // R9: overflow flag is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> ovf_o);

endmodule

bind noise_shaper3 ns3_chk #(
    .CODE_W (CODE_W),
    .MAXC   (LEVELS)
) i_ns3_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .din_vld_i  (din_vld_i),
    .code_o     (code_o),
    .code_vld_o (code_vld_o),
    .ovf_o      (ovf_o),
    .lfsr_now   (lfsr_now)
);

// File: tb/test_noise_shaper3.sv
module test_noise_shaper3;

    localparam int DW     = 32;
    localparam int QB     = 5;
    localparam int STEP   = 26;
    localparam int GRD    = 4;
    localparam int ACCW   = DW + GRD;
    localparam logic [34:0] TB_SEED = 35'h5_1D3C_2B79;

    localparam longint ONE_STEP = longint'(1) <<< STEP;
    localparam longint SAT_HI   = (longint'(1) <<< (ACCW - 1)) - 1;
    localparam longint SAT_LO   = -(longint'(1) <<< (ACCW - 1));

    typedef struct packed {
        longint dc;
        bit     den;
    } vec_t;

    // DC stimulus table: the expected mean code level equals dc (R6)
    localparam vec_t TAB [7] = '{
        '{64'sd0,          1'b0},
        '{64'sd0,          1'b1},
        '{64'sd201338457,  1'b1},
        '{-64'sd335545097, 1'b1},
        '{64'sd1048576,    1'b0},
        '{64'sd402653184,  1'b1},
        '{-64'sd402653183, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] din;
    logic          vld;
    logic          den;
    logic [QB:0]   code;
    logic          cvld;
    logic          ovf;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    int  last_code;

    longint      m_s1, m_s2, m_s3;
    logic [34:0] m_lfsr;
    bit          m_ovf;

    always #5 clk = ~clk;

    noise_shaper3 #(
        .DATA_W (DW),
        .Q_BITS (QB),
        .STEP_W (STEP),
        .GUARD  (GRD),
        .SEED   (TB_SEED)
    ) i_noise_shaper3 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .din_i      (din),
        .din_vld_i  (vld),
        .dith_en_i  (den),
        .code_o     (code),
        .code_vld_o (cvld),
        .ovf_o      (ovf)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint satf(input longint a);
        if (a > SAT_HI) return SAT_HI;
        if (a < SAT_LO) return SAT_LO;
        return a;
    endfunction

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_s3 = 0;
        m_lfsr = TB_SEED;
        m_ovf = 1'b0;
        last_code = 16;
    endtask

    // Reference loop from R4, R5, R7, R8, R9
    task automatic model_step(input longint x, input bit dith, output int ec);
        longint d, v, q, fb, e, n1, n2, n3;
        d = 0;
        if (dith) d = longint'($signed(m_lfsr[2:0])) * (longint'(1) <<< (STEP - 3));
        v = x + 3 * m_s1 + 3 * m_s2 + m_s3 + d;
        q = (v + (longint'(1) <<< (STEP - 1))) >>> STEP;
        if (q >= 16) ec = 32;
        else if (q <= -16) ec = 0;
        else ec = int'(q) + 16;
        fb = longint'(ec - 16) * ONE_STEP;
        e  = x - fb;
        n1 = satf(m_s1 + e);
        n2 = satf(m_s2 + m_s1);
        n3 = satf(m_s3 + m_s2);
        if (n1 != m_s1 + e || n2 != m_s2 + m_s1 || n3 != m_s3 + m_s2) m_ovf = 1'b1;
        m_s1 = n1; m_s2 = n2; m_s3 = n3;
        m_lfsr = {m_lfsr[33:0], m_lfsr[34] ^ m_lfsr[32]};
    endtask

    // Called at a falling edge; returns at the next falling edge with the result checked
    task automatic send(input longint x, input bit dith, input string req, output int got);
        int ec;
        din = x[DW-1:0];
        vld = 1'b1;
        den = dith;
        model_step(x, dith, ec);
        @(negedge clk);
        got = int'(code);
        check(int'(code) == ec, req, longint'(code), longint'(ec));
        check(cvld == 1'b1, "R2", longint'(cvld), 1);
        check(ovf == m_ovf, "R9", longint'(ovf), longint'(m_ovf));
        last_code = int'(code);
    endtask

    task automatic idle(input int n, input logic [DW-1:0] junk);
        vld = 1'b0;
        din = junk;
        den = ~den;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cvld == 1'b0, "R2", longint'(cvld), 0);
            check(int'(code) == last_code, "R3", longint'(code), longint'(last_code));
            check(ovf == m_ovf, "R9", longint'(ovf), longint'(m_ovf));
        end
    endtask

    task automatic do_reset();
        vld   = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(code == 7'd16, "R1", longint'(code), 16);
        check(cvld == 1'b0, "R1", longint'(cvld), 0);
        check(ovf == 1'b0, "R1", longint'(ovf), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int     got;
        longint sum, mean, diff;

        rst_n = 1'b0; vld = 1'b0; den = 1'b0; din = '0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1: values held during reset
        check(code == 7'd16, "R1", longint'(code), 16);
        check(cvld == 1'b0, "R1", longint'(cvld), 0);
        check(ovf == 1'b0, "R1", longint'(ovf), 0);

        // Table walk: bit-exact loop (R5, R7 with dither) and DC tracking (R6)
        for (int t = 0; t < 7; t++) begin
            do_reset();
            sum = 0;
            for (int k = 0; k < 256; k++) begin
                send(TAB[t].dc, TAB[t].den, TAB[t].den ? "R7" : "R5", got);
                sum += longint'(got - 16) * ONE_STEP;
            end
            vld  = 1'b0;
            mean = sum / 256;
            diff = mean - TAB[t].dc;
            if (diff < 0) diff = -diff;
            check(diff <= ONE_STEP, "R6", mean, TAB[t].dc);
        end

        // Varying input, dither toggling, idle gaps with junk data:
        // R8 (register advances on every accepted sample), R3 (gaps change nothing)
        do_reset();
        for (int k = 0; k < 40; k++) begin
            send(longint'(k) * 9000011 - 150000000, k[1], "R8", got);
            if (k % 5 == 2) idle(2, DW'(32'hDEAD_BEEF ^ k));
        end

        // R4: lower clamp
        do_reset();
        send(-64'sd2147483648, 1'b0, "R4", got);
        check(got == 0, "R4", longint'(got), 0);

        // R4 upper clamp, then sustained overload drives the integrators to their limits (R9)
        do_reset();
        send(64'sd2147483647, 1'b1, "R4", got);
        check(got == 32, "R4", longint'(got), 32);
        for (int k = 0; k < 13; k++) begin
            send(64'sd2147483647, 1'b0, "R5", got);
        end
        check(ovf == 1'b1, "R9", longint'(ovf), 1);
        idle(3, '0);
        send(0, 1'b0, "R9", got);
        send(0, 1'b1, "R9", got);
        check(ovf == 1'b1, "R9", longint'(ovf), 1);

        // R1: reset clears the sticky flag
        do_reset();
        check(ovf == 1'b0, "R1", longint'(ovf), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule